// File: doc/BRIEF.md
# Key-Locked Configuration Register File

This block is a small bank of 32-bit configuration words on a word-addressed request/response bus. It holds a set of general control words, a fixed identification word, and a status word that captures event pulses from four cores. Each core has two event inputs: a non-maskable interrupt and a local reset.

Writes that would change configuration are guarded by a two-key lock. The lock is engaged at reset. Software writes a distinct magic value to each of two key slots, in either order, to release the lock. After its updates, software writes any other value to either key slot, and the lock closes again. A blocked write is dropped and flagged with an error bit on its response. Reads are never blocked.

Every request gets its response exactly one cycle later. Status bits are sticky. Software clears them by writing ones, and a clear is accepted only while the lock is open.

Top module: `cfg_lockbank`

## Requirements
- R1: After reset the lock is engaged, every control word reads 0 and the status word reads 0.
- R2: While locked, a write to a control word is dropped and its response has the error bit set to 1.
- R3: The lock opens only once key slot A (word 0) holds 0x83E70B13 and key slot B (word 1) holds 0x95A4F1E0, written in either order. While open, control words (words 4 up to 4+NCTRL-1) accept writes with no error.
- R4: Writing a value other than its key to either key slot engages the lock and forgets both keys, so a later correct write to a single slot does not open the lock. Key slot writes never return an error.
- R5: Word 2 reads {variant[3:0], part[15:0], manufacturer[10:0], 1'b1}, with the fields at bits 31:28, 27:12, 11:1 and 0. Writes to it are always dropped with the error bit set, whether the lock is open or not.
- R6: Status word 3 captures core_nmi[3:0] into bits 11:8 and core_lrst[3:0] into bits 3:0. A high input sets its bit, the bit stays set after the input falls, and all other bits read 0.
- R7: Writing 1s to the status word clears the matching bits only while the lock is open. While locked, the write changes nothing and returns the error bit.
- R8: When an event input is high in the same cycle that software clears its status bit, the bit stays set.
- R9: Reads of either key slot return 0.
- R10: resp_valid is high exactly in the cycle after a request is accepted. resp_err is 0 whenever resp_valid is 0.
- R11: A request to a word index outside 0 to 3+NCTRL reads 0 with the error bit set, and a write to such an index returns the error bit and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word index |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present (one cycle after request) |
| resp_rdata | output | 32 | Read data (0 for writes) |
| resp_err | output | 1 | Request was blocked or unmapped |
| core_nmi | input | 4 | Per-core non-maskable interrupt events |
| core_lrst | input | 4 | Per-core local reset events |

## Verification
Two functions can land on the same status bit in the same clock edge: an event input latching the bit, and a write-one clear issued by software. The bench raises core_nmi[0] and keeps it high across the very edge that carries an unlocked clear of bits 8 and 0. It then reads the status word back. Bit 8 must survive and bit 0 must be gone. The bench also sweeps all sixteen patterns of each event bus against locked and unlocked clears, and compares each readback with a status model kept in the bench.

// File: rtl/cfg_lockbank.sv
module cfg_lockbank #(
  parameter int          AW         = 6,
  parameter int          NCTRL      = 4,
  parameter logic [3:0]  ID_VARIANT = 4'h2,
  parameter logic [15:0] ID_PART    = 16'hC3E1,
  parameter logic [10:0] ID_MFR     = 11'h05B,
  parameter logic [31:0] KEY_A      = 32'h83E70B13,
  parameter logic [31:0] KEY_B      = 32'h95A4F1E0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          resp_valid,
  output logic [31:0]   resp_rdata,
  output logic          resp_err,
  input  logic [3:0]    core_nmi,
  input  logic [3:0]    core_lrst
);
  localparam logic [AW-1:0] IX_KA = AW'(0);
  localparam logic [AW-1:0] IX_KB = AW'(1);
  localparam logic [AW-1:0] IX_ID = AW'(2);
  localparam logic [AW-1:0] IX_ST = AW'(3);
  localparam int            IX_C0 = 4;
  localparam logic [31:0]   ID_WORD = {ID_VARIANT, ID_PART, ID_MFR, 1'b1};

  logic                   ka_ok, kb_ok;
  logic [3:0]             nmi_q, lrst_q;
  logic [NCTRL-1:0][31:0] ctrl_q;
  logic [31:0]            rmux;

  wire unlocked = ka_ok & kb_ok;
  wire wr       = req_valid & req_write;
  wire rd       = req_valid & ~req_write;
  wire hit_ctrl = (int'(req_addr) >= IX_C0) && (int'(req_addr) < IX_C0 + NCTRL);
  wire unmapped = !hit_ctrl && (int'(req_addr) > 3);
  wire guarded  = hit_ctrl || (req_addr == IX_ST);
  wire wr_err   = wr && ((req_addr == IX_ID) || unmapped || (guarded && !unlocked));
  wire st_clr   = wr && unlocked && (req_addr == IX_ST);
  wire [3:0] clr_nmi  = st_clr ? req_wdata[11:8] : 4'h0;
  wire [3:0] clr_lrst = st_clr ? req_wdata[3:0]  : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ka_ok <= 1'b0;
      kb_ok <= 1'b0;
    end else if (wr && req_addr == IX_KA) begin
      if (req_wdata == KEY_A) ka_ok <= 1'b1;
      else begin
        ka_ok <= 1'b0;
        kb_ok <= 1'b0;
      end
    end else if (wr && req_addr == IX_KB) begin
      if (req_wdata == KEY_B) kb_ok <= 1'b1;
      else begin
        ka_ok <= 1'b0;
        kb_ok <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n)                                              ctrl_q[g] <= '0;
      else if (wr && unlocked && int'(req_addr) == IX_C0 + g) ctrl_q[g] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q  <= '0;
      lrst_q <= '0;
    end else begin
      nmi_q  <= (nmi_q  & ~clr_nmi)  | core_nmi;
      lrst_q <= (lrst_q & ~clr_lrst) | core_lrst;
    end
  end

  always_comb begin
    rmux = '0;
    if (req_addr == IX_ID)      rmux = ID_WORD;
    else if (req_addr == IX_ST) rmux = {20'h0, nmi_q, 4'h0, lrst_q};
    else if (hit_ctrl)          rmux = ctrl_q[int'(req_addr) - IX_C0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_rdata <= rd ? rmux : 32'h0;
      resp_err   <= wr_err || (rd && unmapped);
    end
  end
endmodule

// File: rtl/cfg_lockbank_chk.sv
module cfg_lockbank_chk #(
  parameter int          AW    = 6,
  parameter int          NCTRL = 4,
  parameter logic [31:0] KEY_A = 32'h83E70B13,
  parameter logic [31:0] KEY_B = 32'h95A4F1E0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [AW-1:0]          req_addr,
  input logic [31:0]            req_wdata,
  input logic                   resp_valid,
  input logic [31:0]            resp_rdata,
  input logic                   resp_err,
  input logic [3:0]             core_nmi,
  input logic [3:0]             core_lrst,
  input logic                   unlocked,
  input logic [3:0]             nmi_q,
  input logic [3:0]             lrst_q,
  input logic [NCTRL-1:0][31:0] ctrl_q
);
  assert_locked_ctrl_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !unlocked) |=> $stable(ctrl_q));

  assert_bad_key_relocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write &&
     ((req_addr == AW'(0) && req_wdata != KEY_A) || (req_addr == AW'(1) && req_wdata != KEY_B)))
    |=> !unlocked);

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=>
      ((nmi_q & $past(nmi_q)) == $past(nmi_q)) && ((lrst_q & $past(lrst_q)) == $past(lrst_q)));

  assert_status_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == AW'(3)) |=>
      (resp_rdata[31:12] == 20'h0 && resp_rdata[7:4] == 4'h0));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|{core_nmi, core_lrst}) |=>
      ((nmi_q & $past(core_nmi)) == $past(core_nmi)) && ((lrst_q & $past(core_lrst)) == $past(core_lrst)));

  assert_key_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr == AW'(0) || req_addr == AW'(1))) |=> resp_rdata == 32'h0);

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  assert_err_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_valid);
endmodule

bind cfg_lockbank cfg_lockbank_chk #(.AW(AW), .NCTRL(NCTRL), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
  .resp_rdata(resp_rdata), .resp_err(resp_err), .core_nmi(core_nmi),
  .core_lrst(core_lrst), .unlocked(unlocked), .nmi_q(nmi_q), .lrst_q(lrst_q),
  .ctrl_q(ctrl_q)
);

// File: tb/cfg_lockbank_tb.sv
module cfg_lockbank_tb;
  localparam int          AW = 6, NCTRL = 4;
  localparam logic [3:0]  VAR = 4'h2;
  localparam logic [15:0] PART = 16'hC3E1;
  localparam logic [10:0] MFR = 11'h05B;
  localparam logic [31:0] KA = 32'h83E70B13, KB = 32'h95A4F1E0;
  localparam logic [31:0] EXP_ID = (32'(VAR) << 28) | (32'(PART) << 12) | (32'(MFR) << 1) | 32'h1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [3:0] core_nmi = '0, core_lrst = '0;
  int nchk = 0, nfail = 0;
  logic [31:0] exp_st = '0;
  logic [31:0] rd_v;
  logic er_v;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_lockbank #(.AW(AW), .NCTRL(NCTRL), .ID_VARIANT(VAR), .ID_PART(PART), .ID_MFR(MFR),
                 .KEY_A(KA), .KEY_B(KB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .resp_err(resp_err), .core_nmi(core_nmi), .core_lrst(core_lrst));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input int a, input logic [31:0] d,
                      output logic [31:0] r, output logic e);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    check("R10 resp_valid", 32'(resp_valid), 32'h1);
    r = resp_rdata; e = resp_err;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic exp_err, input string tag);
    xfer(1'b1, a, d, rd_v, er_v);
    check(tag, 32'(er_v), 32'(exp_err));
  endtask

  task automatic rdchk(input int a, input logic [31:0] exp, input logic exp_err, input string tag);
    xfer(1'b0, a, 32'h0, rd_v, er_v);
    check(tag, rd_v, exp);
    check(tag, 32'(er_v), 32'(exp_err));
  endtask

  task automatic pulse(input logic [3:0] n, input logic [3:0] l);
    @(negedge clk);
    core_nmi = n; core_lrst = l;
    @(negedge clk);
    core_nmi = 0; core_lrst = 0;
    exp_st = exp_st | (32'(n) << 8) | 32'(l);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1234_5678 ^ (32'(i) * 32'h0101_0101);
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle no resp", 32'(resp_valid), 32'h0);
    for (int i = 0; i < NCTRL; i++) rdchk(4 + i, 32'h0, 1'b0, "R1 ctrl reset");
    rdchk(3, 32'h0, 1'b0, "R1 status reset");
    rdchk(2, EXP_ID, 1'b0, "R5 id layout");
    rdchk(0, 32'h0, 1'b0, "R9 key A read");
    rdchk(1, 32'h0, 1'b0, "R9 key B read");

    for (int i = 0; i < NCTRL; i++) begin
      wr(4 + i, pat(i), 1'b1, "R2 locked write err");
      rdchk(4 + i, 32'h0, 1'b0, "R2 locked write dropped");
    end

    wr(0, KA, 1'b0, "R4 key write no err");
    wr(4, pat(0), 1'b1, "R3 one key insufficient");
    wr(1, KB, 1'b0, "R4 key write no err");
    for (int i = 0; i < NCTRL; i++) wr(4 + i, pat(i), 1'b0, "R3 unlocked write ok");
    for (int i = 0; i < NCTRL; i++) rdchk(4 + i, pat(i), 1'b0, "R3 unlocked readback");
    rdchk(0, 32'h0, 1'b0, "R9 key A read unlocked");
    rdchk(1, 32'h0, 1'b0, "R9 key B read unlocked");
    wr(2, 32'hFFFF_FFFF, 1'b1, "R5 id write err");
    rdchk(2, EXP_ID, 1'b0, "R5 id unchanged");

    wr(1, KB ^ 32'h1, 1'b0, "R4 wrong key no err");
    wr(4, 32'hDEAD_BEEF, 1'b1, "R4 relocked after bad B");
    rdchk(4, pat(0), 1'b0, "R4 ctrl kept");
    wr(0, KA, 1'b0, "R4 key write");
    wr(5, 32'hDEAD_BEEF, 1'b1, "R4 keys forgotten");
    wr(1, KB, 1'b0, "R4 key write");
    wr(0, KA, 1'b0, "R4 key write");
    wr(6, 32'hCAFE_0006, 1'b0, "R3 reverse order unlocks");
    rdchk(6, 32'hCAFE_0006, 1'b0, "R3 reverse order readback");
    wr(0, 32'h0, 1'b0, "R4 wrong key no err");
    wr(6, 32'h0, 1'b1, "R4 relocked after bad A");
    rdchk(6, 32'hCAFE_0006, 1'b0, "R4 ctrl kept");

    for (int p = 0; p < 16; p++) begin
      pulse(4'(p), 4'(p) ^ 4'hF);
      rdchk(3, exp_st, 1'b0, "R6 status latch");
      rdchk(3, exp_st, 1'b0, "R6 status sticky");
      wr(3, 32'hFFFF_FFFF, 1'b1, "R7 locked clear err");
      rdchk(3, exp_st, 1'b0, "R7 locked clear ignored");
      wr(0, KA, 1'b0, "R3 key"); wr(1, KB, 1'b0, "R3 key");
      wr(3, 32'h0000_0F0F & ~(32'(p) << 8), 1'b0, "R7 unlocked clear");
      exp_st = exp_st & (32'(p) << 8);
      rdchk(3, exp_st, 1'b0, "R7 partial clear");
      wr(3, 32'h0000_0F00, 1'b0, "R7 unlocked clear");
      exp_st = 0;
      rdchk(3, 32'h0, 1'b0, "R7 cleared");
      wr(1, 32'h0, 1'b0, "R4 relock");
    end

    wr(0, KA, 1'b0, "R3 key"); wr(1, KB, 1'b0, "R3 key");
    pulse(4'h1, 4'h1);
    rdchk(3, 32'h0000_0101, 1'b0, "R8 setup");
    core_nmi = 4'h1;
    wr(3, 32'h0000_0101, 1'b0, "R8 clear during event");
    core_nmi = 4'h0;
    rdchk(3, 32'h0000_0100, 1'b0, "R8 event wins over clear");
    core_lrst = 4'h8;
    wr(3, 32'h0000_0108, 1'b0, "R8 clear during new event");
    core_lrst = 4'h0;
    rdchk(3, 32'h0000_0008, 1'b0, "R8 new event kept");

    rdchk(4 + NCTRL, 32'h0, 1'b1, "R11 unmapped read");
    rdchk(63, 32'h0, 1'b1, "R11 top unmapped read");
    wr(4 + NCTRL, 32'h1111_1111, 1'b1, "R11 unmapped write");
    for (int i = 0; i < NCTRL; i++)
      rdchk(4 + i, (i == 2) ? 32'hCAFE_0006 : pat(i), 1'b0, "R11 no side effect");
    @(negedge clk);
    check("R10 idle no resp", 32'(resp_valid), 32'h0);
    check("R10 idle no err", 32'(resp_err), 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule